// File: doc/BRIEF.md
# Host Link Sleep Sequencer

This block sits on the host side of a serial storage link. It decides when to raise the sideband sleep line to the attached drive, and it sequences both the entry into and the exit from that deep interface sleep. Software asks for sleep with a level request. The block raises the line only when three guards hold: the drive has reported the capability, the feature has been switched on, and the outstanding-command count is zero. The current link power state does not matter: full power, Partial and Slumber are all valid starting points.

While the line is high, the block raises a power-down enable for the PHY and its clocking. It also blocks transmit requests, so the host starts no link traffic, and it masks received PHY activity. A command submitted during this time is held back and flagged as an error. A counter driven by a millisecond tick enforces a minimum hold time. That time is the larger of a configured value and a built-in floor of 10 ms.

A wake request that arrives before the hold has elapsed is latched. The exit happens once the hold has elapsed and a wake is pending or present. On exit the line drops, and in the same cycle the block emits a one-cycle request for the chosen out-of-band renegotiation signal: the wake burst or the link reset.

Top module: `link_sleep_seq`

## Requirements
- R1: The sleep line rises one cycle after a cycle in which `sleep_req`, `dev_cap` and `feat_en` are all 1 and `cmd_pending` is 0, with the block awake. If any guard fails, it stays low.
- R2: Once high, the sleep line stays high until `ms_tick` has been sampled high in at least H cycles during the sleep. H is `min_hold_cfg`, or `DEF_HOLD` (10) when `min_hold_cfg` is smaller than that.
- R3: While the sleep line is high, `tx_req_out` is 0. Otherwise it equals `phy_tx_req`.
- R4: While the sleep line is high, `rx_act_out` is 0. Otherwise it equals `phy_rx_act`.
- R5: A `wake_req` pulse that arrives during the sleep is remembered, and the line drops one cycle after the first cycle in which the hold is met and a wake is pending or present. A `wake_req` pulse while awake has no effect.
- R6: In the cycle the sleep line drops, exactly one of `wake_comwake` and `wake_comreset` is 1, for one cycle. `wake_comwake` is chosen when `wake_sel` was 0 in the deciding cycle, and `wake_comreset` when it was 1.
- R7: `phy_pd_en` is 1 exactly while the sleep line is high.
- R8: A `cmd_submit` while the sleep line is high gives `cmd_err`=1 and `cmd_fwd`=0. Otherwise `cmd_fwd` follows `cmd_submit` and `cmd_err` is 0.
- R9: After reset, all outputs are 0.
- R10: In the cycle of the wake pulse the block cannot re-enter sleep. The line can rise again at the earliest two cycles after it dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| dev_cap | input | 1 | Drive reports sleep capability |
| feat_en | input | 1 | Feature enabled by host software |
| cmd_pending | input | CNT_W | Outstanding-command count |
| sleep_req | input | 1 | Software sleep request (level) |
| wake_req | input | 1 | Wake request (pulse) |
| wake_sel | input | 1 | Exit signal choice: 0 wake burst, 1 link reset |
| min_hold_cfg | input | HOLD_W | Configured minimum hold in ms |
| phy_tx_req | input | 1 | Transmit request toward the PHY |
| phy_rx_act | input | 1 | Received activity from the PHY |
| cmd_submit | input | 1 | Command submission strobe |
| sleep_line | output | 1 | Sideband sleep line to the drive |
| phy_pd_en | output | 1 | PHY and clocking power-down enable |
| tx_req_out | output | 1 | Gated transmit request |
| rx_act_out | output | 1 | Gated receive activity |
| wake_comwake | output | 1 | One-cycle wake-burst request |
| wake_comreset | output | 1 | One-cycle link-reset request |
| cmd_err | output | 1 | Command submitted during sleep |
| cmd_fwd | output | 1 | Command passed to the link |

## Verification
The bench targets several corner cases, each with a distinct failure mode.

- **Wake before the hold elapses.** A design that dropped this wake would sleep forever. One that acted on it at once would cut the hold short.
- **Configured hold below the 10 ms floor.** A design that trusted the configured value would release early.
- **Each entry guard failing alone.** A design with a missing guard would raise the line with commands still outstanding.
- **Sleep request held high across an exit.** A design that re-entered in the wake cycle would overlap the renegotiation with a new sleep.
- **Command submitted while asleep.** The bench checks that it is refused rather than forwarded.
- **Exit selector flipping near the deciding cycle.** The bench checks that the pulse type comes from that cycle.

// File: rtl/link_sleep_seq.sv
module link_sleep_seq #(
  parameter int HOLD_W   = 8,
  parameter int CNT_W    = 6,
  parameter int DEF_HOLD = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              dev_cap,
  input  logic              feat_en,
  input  logic [CNT_W-1:0]  cmd_pending,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              wake_sel,
  input  logic [HOLD_W-1:0] min_hold_cfg,
  input  logic              phy_tx_req,
  input  logic              phy_rx_act,
  input  logic              cmd_submit,
  output logic              sleep_line,
  output logic              phy_pd_en,
  output logic              tx_req_out,
  output logic              rx_act_out,
  output logic              wake_comwake,
  output logic              wake_comreset,
  output logic              cmd_err,
  output logic              cmd_fwd
);

  localparam logic [HOLD_W-1:0] FLOOR   = HOLD_W'(DEF_HOLD);
  localparam logic [HOLD_W-1:0] CNT_TOP = '1;

  typedef enum logic [1:0] {ST_AWAKE, ST_ASLEEP, ST_RELEASE} st_t;

  st_t               st;
  logic [HOLD_W-1:0] held_ms;
  logic              wake_pend;
  logic              exit_sel;

  logic [HOLD_W-1:0] hold_need;
  logic              guards_ok;
  logic              hold_met;
  logic              leave_now;

  assign hold_need = (min_hold_cfg < FLOOR) ? FLOOR : min_hold_cfg;
  assign guards_ok = sleep_req && dev_cap && feat_en && (cmd_pending == '0);
  assign hold_met  = held_ms >= hold_need;
  assign leave_now = hold_met && (wake_pend || wake_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_AWAKE;
      held_ms   <= '0;
      wake_pend <= 1'b0;
      exit_sel  <= 1'b0;
    end else begin
      case (st)
        ST_AWAKE: begin
          if (guards_ok) begin
            st        <= ST_ASLEEP;
            held_ms   <= '0;
            wake_pend <= 1'b0;
          end
        end
        ST_ASLEEP: begin
          if (ms_tick && held_ms != CNT_TOP) held_ms <= held_ms + 1'b1;
          if (wake_req) wake_pend <= 1'b1;
          if (leave_now) begin
            st        <= ST_RELEASE;
            exit_sel  <= wake_sel;
            wake_pend <= 1'b0;
          end
        end
        default: st <= ST_AWAKE;
      endcase
    end
  end

  assign sleep_line    = (st == ST_ASLEEP);
  assign phy_pd_en     = sleep_line;
  assign tx_req_out    = phy_tx_req & ~sleep_line;
  assign rx_act_out    = phy_rx_act & ~sleep_line;
  assign wake_comwake  = (st == ST_RELEASE) & ~exit_sel;
  assign wake_comreset = (st == ST_RELEASE) &  exit_sel;
  assign cmd_err       = cmd_submit &  sleep_line;
  assign cmd_fwd       = cmd_submit & ~sleep_line;

endmodule

module link_sleep_seq_chk #(
  parameter int HOLD_W   = 8,
  parameter int CNT_W    = 6,
  parameter int DEF_HOLD = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_tick,
  input logic              dev_cap,
  input logic              feat_en,
  input logic [CNT_W-1:0]  cmd_pending,
  input logic              sleep_req,
  input logic [HOLD_W-1:0] min_hold_cfg,
  input logic              phy_tx_req,
  input logic              sleep_line,
  input logic              phy_pd_en,
  input logic              tx_req_out,
  input logic              rx_act_out,
  input logic              wake_comwake,
  input logic              wake_comreset,
  input logic              cmd_err,
  input logic              cmd_fwd
);
  logic [HOLD_W:0] ticks_seen;
  logic [HOLD_W:0] need;
  assign need = (min_hold_cfg < HOLD_W'(DEF_HOLD)) ? (HOLD_W+1)'(DEF_HOLD) : {1'b0, min_hold_cfg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ticks_seen <= '0;
    else if (!sleep_line) ticks_seen <= '0;
    else if (ms_tick && ticks_seen != '1) ticks_seen <= ticks_seen + 1'b1;
  end

  // R1
  entry_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_line) |-> $past(sleep_req && dev_cap && feat_en && cmd_pending == '0));

  // R2
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_line) |-> $past(ticks_seen) >= $past(need));

  // R3
  tx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_line |-> !tx_req_out);

  // R4
  rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_line |-> !rx_act_out);

  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_line) |-> $onehot({wake_comwake, wake_comreset}));

  // R6
  wake_only_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_comwake || wake_comreset) |-> $past(sleep_line) && !sleep_line);

  // R7
  pd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_pd_en |-> sleep_line);

  // R8
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_err && cmd_fwd));

  // R10
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_comwake || wake_comreset) |=> !sleep_line);

  // R3
  tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_line && phy_tx_req) |-> tx_req_out);
endmodule

bind link_sleep_seq link_sleep_seq_chk #(
  .HOLD_W(HOLD_W), .CNT_W(CNT_W), .DEF_HOLD(DEF_HOLD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .dev_cap(dev_cap), .feat_en(feat_en),
  .cmd_pending(cmd_pending), .sleep_req(sleep_req), .min_hold_cfg(min_hold_cfg),
  .phy_tx_req(phy_tx_req), .sleep_line(sleep_line), .phy_pd_en(phy_pd_en),
  .tx_req_out(tx_req_out), .rx_act_out(rx_act_out), .wake_comwake(wake_comwake),
  .wake_comreset(wake_comreset), .cmd_err(cmd_err), .cmd_fwd(cmd_fwd)
);

// File: tb/sim_link_sleep_seq.sv
module sim_link_sleep_seq;
  localparam int HOLD_W = 8;
  localparam int CNT_W  = 6;
  localparam int DEF_HOLD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 0, dev_cap = 0, feat_en = 0, sleep_req = 0, wake_req = 0, wake_sel = 0;
  logic [CNT_W-1:0] cmd_pending = '0;
  logic [HOLD_W-1:0] min_hold_cfg = '0;
  logic phy_tx_req = 0, phy_rx_act = 0, cmd_submit = 0;
  logic sleep_line, phy_pd_en, tx_req_out, rx_act_out, wake_comwake, wake_comreset, cmd_err, cmd_fwd;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // reference state
  int  m_st = 0;
  int  m_held = 0;
  bit  m_pend = 0;
  bit  m_sel = 0;

  always #5 clk = ~clk;

  link_sleep_seq #(.HOLD_W(HOLD_W), .CNT_W(CNT_W), .DEF_HOLD(DEF_HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .dev_cap(dev_cap), .feat_en(feat_en),
    .cmd_pending(cmd_pending), .sleep_req(sleep_req), .wake_req(wake_req), .wake_sel(wake_sel),
    .min_hold_cfg(min_hold_cfg), .phy_tx_req(phy_tx_req), .phy_rx_act(phy_rx_act),
    .cmd_submit(cmd_submit), .sleep_line(sleep_line), .phy_pd_en(phy_pd_en),
    .tx_req_out(tx_req_out), .rx_act_out(rx_act_out), .wake_comwake(wake_comwake),
    .wake_comreset(wake_comreset), .cmd_err(cmd_err), .cmd_fwd(cmd_fwd));

  function automatic int need_ms(input logic [HOLD_W-1:0] cfg);
    return (int'(cfg) < DEF_HOLD) ? DEF_HOLD : int'(cfg);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit asleep;
    asleep = (m_st == 1);
    chk("R1,R2,R5,R10 sleep_line", sleep_line, asleep);
    chk("R7 phy_pd_en", phy_pd_en, asleep);
    chk("R3 tx_req_out", tx_req_out, phy_tx_req & ~asleep);
    chk("R4 rx_act_out", rx_act_out, phy_rx_act & ~asleep);
    chk("R6 wake_comwake", wake_comwake, (m_st == 2) && !m_sel);
    chk("R6 wake_comreset", wake_comreset, (m_st == 2) && m_sel);
    chk("R8 cmd_err", cmd_err, cmd_submit & asleep);
    chk("R8 cmd_fwd", cmd_fwd, cmd_submit & ~asleep);
  endtask

  task automatic advance();
    bit met;
    met = m_held >= need_ms(min_hold_cfg);
    case (m_st)
      0: if (sleep_req && dev_cap && feat_en && cmd_pending == 0) begin
           m_st = 1; m_held = 0; m_pend = 0;
         end
      1: begin
           bit go;
           go = met && (m_pend || wake_req);
           if (ms_tick && m_held < 255) m_held++;
           if (wake_req) m_pend = 1;
           if (go) begin m_st = 2; m_sel = wake_sel; m_pend = 0; end
         end
      default: m_st = 0;
    endcase
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    advance();
    @(negedge clk);
  endtask

  task automatic quiet();
    ms_tick = 0; wake_req = 0; cmd_submit = 0; phy_tx_req = 0; phy_rx_act = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sleep_line", sleep_line, 0);
    chk("R9 phy_pd_en", phy_pd_en, 0);
    chk("R9 wake_comwake", wake_comwake, 0);
    chk("R9 wake_comreset", wake_comreset, 0);
    chk("R9 cmd_err", cmd_err, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 each guard failing alone
    sleep_req = 1; dev_cap = 0; feat_en = 1; cmd_pending = 0; step(); step();
    dev_cap = 1; feat_en = 0; step(); step();
    feat_en = 1; cmd_pending = 3; step(); step();
    // R5 wake while awake ignored
    sleep_req = 0; cmd_pending = 0; wake_req = 1; step(); wake_req = 0; step();

    // R2 floor: cfg 3 -> 10 ms; R5 early wake latched; R6 comwake
    min_hold_cfg = 3; wake_sel = 0; sleep_req = 1; step(); sleep_req = 0; step();
    wake_req = 1; step(); wake_req = 0;
    cmd_submit = 1; phy_tx_req = 1; phy_rx_act = 1; step(); quiet(); // R8 R3 R4
    for (int i = 0; i < 40; i++) begin ms_tick = (i % 3 == 0); step(); end
    quiet(); repeat (3) step();

    // R2 larger cfg; R6 comreset; R10 held sleep_req across exit
    min_hold_cfg = 14; wake_sel = 1; sleep_req = 1; step();
    for (int i = 0; i < 30; i++) begin ms_tick = (i % 2 == 0); step(); end
    ms_tick = 0; wake_req = 1; step(); wake_req = 0;
    for (int i = 0; i < 6; i++) step();
    sleep_req = 0; wake_req = 1; step(); wake_req = 0; repeat (4) step();

    // R6 selector flips right after the deciding cycle
    sleep_req = 1; min_hold_cfg = 0; step(); sleep_req = 0;
    for (int i = 0; i < 12; i++) begin ms_tick = 1; step(); end
    ms_tick = 0; wake_sel = 0; wake_req = 1; step(); wake_req = 0; wake_sel = 1; repeat (3) step();

    // random mix
    for (int i = 0; i < 6000; i++) begin
      sleep_req   = ($urandom % 4) == 0;
      wake_req    = ($urandom % 8) == 0;
      ms_tick     = ($urandom % 3) == 0;
      dev_cap     = ($urandom % 8) != 0;
      feat_en     = ($urandom % 8) != 0;
      cmd_pending = (($urandom % 4) == 0) ? CNT_W'($urandom % 5) : '0;
      wake_sel    = $urandom % 2;
      phy_tx_req  = $urandom % 2;
      phy_rx_act  = $urandom % 2;
      cmd_submit  = ($urandom % 5) == 0;
      if (($urandom % 60) == 0) min_hold_cfg = HOLD_W'($urandom % 20);
      step();
    end
    finish_run();
  end
endmodule